// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Chain Sequencer

This block is the control core of a small data transfer engine that peripherals start by raising an interrupt flag. While idle it watches the flags of all sources whose per-source enable is set. It picks the lowest-numbered one and reads that source's first descriptor from an external descriptor memory. A descriptor carries a mode byte, a source address, a destination address and a 16-bit transfer count. The sequencer copies one data word from the source address to the destination address over a request/ready memory port. It then decrements the count and writes the new count back into the same descriptor, so the next activation continues from there.

After the word is moved, the mode byte decides what happens next. With the chain bit set, the sequencer reads the descriptor at the next index and moves another word for the same activation. A chained step performs no end-of-count test and no clearing. With the chain bit clear, the activation ends in one of three ways. The sequencer can clear the source flag itself and keep the CPU interrupt suppressed. It can forward the interrupt to the CPU and leave the flag alone. When the count has run out, it disables the source and forwards the interrupt. The flag and enable registers sit outside the block, which reports each clear as a one-cycle pulse.

Top module: `dtc_chain_seq`

## Requirements
- R1: A descriptor is 56 bits wide: mode byte in bits 55:48, source address in 47:32, destination address in 31:16 and count in 15:0. Mode bit 7 is the chain bit and mode bit 6 is the interrupt-select bit. Mode bits 5:0 have no effect on any output.
- R2: Only the flags of enabled sources count as requests, and requests are sampled only while the sequencer is idle. The lowest-numbered pending source is served first, starting at descriptor index 2*s for source s.
- R3: For each word, the sequencer first makes one read at the source address and then one write of the read data to the destination address. Each access holds its request, address and direction steady until ready is seen.
- R4: After the write is accepted, the count minus one (modulo 2^16) is written back to the same descriptor index in the cycle that follows. A later activation starts from the written-back value.
- R5: When the chain bit is 1, the sequencer next reads the descriptor at the current index plus one, within the same activation. A chained step produces no flag clear, no enable clear and no CPU interrupt, even when its count has reached 0.
- R6: In a non-chained step with interrupt select 0 and a remaining count other than 0, the sequencer pulses the flag clear for that source alone. It raises no CPU interrupt and then returns to idle.
- R7: In a non-chained step with interrupt select 1 and a remaining count other than 0, the sequencer pulses the CPU interrupt with the source number on irq_src and issues no flag clear.
- R8: In a non-chained step whose remaining count is 0, the sequencer pulses the enable clear for that source and the CPU interrupt, and issues no flag clear, whatever the value of interrupt select.
- R9: A count of 0 at fetch wraps to 65535. This is not an end of count, so the step follows R6 or R7.
- R10: After reset the sequencer is idle, with no memory request, no descriptor access and no clear or interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_flag | input | 8 | Interrupt flag of each source |
| src_en | input | 8 | Transfer enable of each source |
| desc_rd_en | output | 1 | Descriptor read strobe; data arrives on the next cycle |
| desc_wr_en | output | 1 | Count write-back strobe |
| desc_idx | output | 4 | Descriptor index for read or write-back |
| desc_rdata | input | 56 | Descriptor read data |
| desc_wr_cnt | output | 16 | Count value written back |
| mem_req | output | 1 | Data memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Data memory address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| flag_clr | output | 8 | One-cycle pulse that clears a source flag |
| en_clr | output | 8 | One-cycle pulse that clears a source enable |
| cpu_irq | output | 1 | One-cycle interrupt forward to the CPU |
| irq_src | output | 3 | Source number carried with cpu_irq |
| busy | output | 1 | High whenever the sequencer is not idle |

## Verification
The bench aims at the places where the end-of-activation logic can go wrong. A chained step whose count reaches 0 must still go on to the next descriptor; if the end test leaked into chained steps, the chain would stop early and the source would be disabled. A fetched count of 0 must wrap to 65535 and not be taken as an end of count, and a repeated activation must resume from the written-back count, which exposes a missing or misplaced write-back. Other tests cover priority among several flags with one of them not enabled, a request raised mid-transfer for a lower-numbered source, reserved mode bits set to ones, and memory latencies from 0 to 5 cycles, which catch an access that drops its request or reads and writes in the wrong order.

// File: rtl/dtc_chain_pkg.sv
// Shared definitions for the transfer chain sequencer.
// Assumes a fixed 8-bit mode byte with two live control bits.
package dtc_chain_pkg;

    localparam int MODE_W = 8;
    // Masks of the two live mode bits; the rest of the byte is ignored.
    localparam logic [MODE_W-1:0] CHAIN_MASK = 8'h80;
    localparam logic [MODE_W-1:0] ISEL_MASK  = 8'h40;

    // Top-level sequencer states, in execution order.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_MOVE,
        ST_WBACK,
        ST_DECIDE
    } seq_state_t;

    // Phases of the single-word mover.
    typedef enum logic [1:0] {
        MV_IDLE,
        MV_READ,
        MV_WRITE
    } mv_phase_t;

endpackage

// File: rtl/dtc_src_pick.sv
// Fixed-priority request picker.
// Returns the lowest-numbered set bit of the pending vector.
// Assumes the pending vector is already masked by the source enables.
module dtc_src_pick #(
    parameter int NSRC  = 8,
    parameter int SRC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    output logic             valid,
    output logic [SRC_W-1:0] sel
);

    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        valid = |pend;
        sel   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) sel = SRC_W'(i);
        end
    end

    // The chosen source is pending and no lower-numbered source is pending.
    assert_lowest_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (pend[sel] && ((pend & ((NSRC'(1) << sel) - NSRC'(1))) == '0)));

endmodule

// File: rtl/dtc_word_mover.sv
// Single-word mover: one read at the source address, then one write of
// that data to the destination address, over a request/ready port.
// Assumes start is only raised while the mover is idle; addresses are
// latched on start.
module dtc_word_mover
    import dtc_chain_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    mv_phase_t         phase;
    logic [ADDR_W-1:0] src_q;
    logic [ADDR_W-1:0] dst_q;
    logic [DATA_W-1:0] data_q;

    // Phase register: idle -> read -> write -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= MV_IDLE;
            src_q  <= '0;
            dst_q  <= '0;
            data_q <= '0;
        end else begin
            case (phase)
                MV_IDLE: if (start) begin
                    src_q <= src_addr;
                    dst_q <= dst_addr;
                    phase <= MV_READ;
                end
                MV_READ: if (mem_ready) begin
                    data_q <= mem_rdata;
                    phase  <= MV_WRITE;
                end
                MV_WRITE: if (mem_ready) phase <= MV_IDLE;
                default: phase <= MV_IDLE;
            endcase
        end
    end

    // Memory port drive from the current phase.
    always_comb begin
        mem_req   = (phase != MV_IDLE);
        mem_we    = (phase == MV_WRITE);
        mem_addr  = (phase == MV_WRITE) ? dst_q : src_q;
        mem_wdata = data_q;
        done      = (phase == MV_WRITE) && mem_ready;
    end

    // A pending access keeps its request, direction and address.
    assert_hold_until_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    // An accepted read is followed directly by a write request.
    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

endmodule

// File: rtl/dtc_outcome.sv
// End-of-step decision: turns chain, interrupt select and the remaining
// count into flag-clear, enable-clear and CPU interrupt pulses.
// Assumes active is high for exactly one cycle per completed step.
module dtc_outcome #(
    parameter int NSRC  = 8,
    parameter int SRC_W = 3,
    parameter int CNT_W = 16
) (
    input  logic             active,
    input  logic             chain,
    input  logic             isel,
    input  logic [CNT_W-1:0] cnt_left,
    input  logic [SRC_W-1:0] src,
    output logic [NSRC-1:0]  flag_clr,
    output logic [NSRC-1:0]  en_clr,
    output logic             cpu_irq
);

    logic end_hit;
    logic do_fclr;
    logic do_eclr;

    // Pick one of the three final outcomes; chained steps pick none.
    always_comb begin
        end_hit = (cnt_left == '0);
        do_fclr = 1'b0;
        do_eclr = 1'b0;
        cpu_irq = 1'b0;
        if (active && !chain) begin
            if (end_hit) begin
                do_eclr = 1'b1;
                cpu_irq = 1'b1;
            end else if (isel) begin
                cpu_irq = 1'b1;
            end else begin
                do_fclr = 1'b1;
            end
        end
    end

    // Per-source decode of the clear pulses.
    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        assign flag_clr[g] = do_fclr && (src == SRC_W'(g));
        assign en_clr[g]   = do_eclr && (src == SRC_W'(g));
    end

endmodule

// File: rtl/dtc_chain_seq.sv
// Transfer chain sequencer top. Idle -> descriptor fetch -> load ->
// word move -> count write-back -> decide, repeating fetch for chained
// descriptors. Assumes a descriptor memory with one-cycle read latency
// and source s owning descriptor slots starting at s * 2**SLOT_W.
module dtc_chain_seq
    import dtc_chain_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int SLOT_W = 1,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    localparam int SRC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int IDX_W  = SRC_W + SLOT_W,
    localparam int DESC_W = MODE_W + 2 * ADDR_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_flag,
    input  logic [NSRC-1:0]   src_en,
    output logic              desc_rd_en,
    output logic              desc_wr_en,
    output logic [IDX_W-1:0]  desc_idx,
    input  logic [DESC_W-1:0] desc_rdata,
    output logic [CNT_W-1:0]  desc_wr_cnt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [NSRC-1:0]   flag_clr,
    output logic [NSRC-1:0]   en_clr,
    output logic              cpu_irq,
    output logic [SRC_W-1:0]  irq_src,
    output logic              busy
);

    localparam int SRC_LSB = CNT_W + ADDR_W;
    localparam int DST_LSB = CNT_W;

    seq_state_t        state;
    logic [SRC_W-1:0]  cur_src;
    logic [IDX_W-1:0]  idx_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NSRC-1:0]   pend;
    logic              pick_valid;
    logic [SRC_W-1:0]  pick_sel;
    logic              mv_done;
    logic              chain_q;
    logic              isel_q;

    // Enabled requests only.
    assign pend = src_flag & src_en;

    dtc_src_pick #(
        .NSRC  (NSRC),
        .SRC_W (SRC_W)
    ) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .valid (pick_valid),
        .sel   (pick_sel)
    );

    dtc_word_mover #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state == ST_LOAD),
        .src_addr  (desc_rdata[SRC_LSB +: ADDR_W]),
        .dst_addr  (desc_rdata[DST_LSB +: ADDR_W]),
        .done      (mv_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    // Mode decode through masks; reserved bits fall away here.
    assign chain_q = |(mode_q & CHAIN_MASK);
    assign isel_q  = |(mode_q & ISEL_MASK);

    // Sequencer state and descriptor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_src <= '0;
            idx_q   <= '0;
            mode_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (pick_valid) begin
                    cur_src <= pick_sel;
                    idx_q   <= {pick_sel, {SLOT_W{1'b0}}};
                    state   <= ST_FETCH;
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    mode_q <= desc_rdata[DESC_W-1 -: MODE_W];
                    cnt_q  <= desc_rdata[CNT_W-1:0];
                    state  <= ST_MOVE;
                end
                ST_MOVE: if (mv_done) begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    state <= ST_WBACK;
                end
                ST_WBACK: state <= ST_DECIDE;
                ST_DECIDE: begin
                    if (chain_q) begin
                        idx_q <= idx_q + IDX_W'(1);
                        state <= ST_FETCH;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Descriptor port and status drive.
    always_comb begin
        desc_rd_en  = (state == ST_FETCH);
        desc_wr_en  = (state == ST_WBACK);
        desc_idx    = idx_q;
        desc_wr_cnt = cnt_q;
        busy        = (state != ST_IDLE);
        irq_src     = cur_src;
    end

    dtc_outcome #(
        .NSRC  (NSRC),
        .SRC_W (SRC_W),
        .CNT_W (CNT_W)
    ) u_outcome (
        .active   (state == ST_DECIDE),
        .chain    (chain_q),
        .isel     (isel_q),
        .cnt_left (cnt_q),
        .src      (cur_src),
        .flag_clr (flag_clr),
        .en_clr   (en_clr),
        .cpu_irq  (cpu_irq)
    );

    // Leaving idle needs an enabled request seen in the idle cycle.
    assert_idle_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(|(src_flag & src_en)));

    // Write-back follows the accepted write with the decremented count.
    assert_wback_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done |=> (desc_wr_en && desc_wr_cnt == $past(cnt_q) - CNT_W'(1)));

    // A chained step is silent and fetches the next index.
    assert_chain_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && chain_q) |-> (flag_clr == '0 && en_clr == '0 && !cpu_irq));
    assert_chain_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && chain_q) |=> (desc_rd_en && desc_idx == $past(desc_idx) + IDX_W'(1)));

    // Flag clears name at most one source and never come with an interrupt.
    assert_flag_clr_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));
    assert_irq_keeps_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (flag_clr == '0));

    // Disabling a source always comes with the CPU interrupt for it.
    assert_en_clr_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr != '0) |-> (cpu_irq && $onehot(en_clr) && en_clr[irq_src]));

    // First cycle out of reset is quiet.
    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!busy && !mem_req && !desc_rd_en && !cpu_irq));

endmodule

// File: tb/tb_dtc_chain_seq.sv
// Bench for dtc_chain_seq: a behavioural model predicts every memory
// write, count write-back and outcome pulse into queues; the outputs are
// compared against them on every falling clock edge.
module tb_dtc_chain_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC   = 8;
    localparam int SRC_W  = 3;
    localparam int IDX_W  = 4;
    localparam int NDESC  = 16;
    localparam int DESC_W = 56;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [NSRC-1:0]   src_flag, src_en;
    logic              desc_rd_en, desc_wr_en;
    logic [IDX_W-1:0]  desc_idx;
    logic [DESC_W-1:0] desc_rdata;
    logic [15:0]       desc_wr_cnt;
    logic              mem_req, mem_we, mem_ready;
    logic [15:0]       mem_addr, mem_wdata, mem_rdata;
    logic [NSRC-1:0]   flag_clr, en_clr;
    logic              cpu_irq;
    logic [SRC_W-1:0]  irq_src;
    logic              busy;

    dtc_chain_seq dut (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_idx(desc_idx),
        .desc_rdata(desc_rdata), .desc_wr_cnt(desc_wr_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .flag_clr(flag_clr), .en_clr(en_clr), .cpu_irq(cpu_irq),
        .irq_src(irq_src), .busy(busy)
    );

    // Bench-side storage and host access
    logic [15:0]       dmem  [0:255];
    logic [DESC_W-1:0] ddesc [0:NDESC-1];
    logic [15:0]       mmem  [0:255];
    logic [DESC_W-1:0] mdesc [0:NDESC-1];
    logic [NSRC-1:0]   m_flag, m_en;
    logic [NSRC-1:0]   set_req, en_set;
    logic              host_mwr, host_dwr;
    logic [7:0]        host_maddr;
    logic [15:0]       host_mdata;
    logic [IDX_W-1:0]  host_didx;
    logic [DESC_W-1:0] host_dval;
    int                lat;
    int                wcnt;

    longint unsigned q_wr[$];
    longint unsigned q_wb[$];
    longint unsigned q_out[$];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Peripheral flag/enable registers with CPU clearing flags on interrupt.
    always @(posedge clk) begin
        if (!rst_n) begin
            src_flag <= '0;
            src_en   <= '0;
        end else begin
            src_flag <= (src_flag | set_req) & ~flag_clr
                        & ~(cpu_irq ? (NSRC'(1) << irq_src) : NSRC'(0));
            src_en   <= (src_en | en_set) & ~en_clr;
        end
    end

    // Data memory with programmable ready latency.
    assign mem_rdata = dmem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (host_mwr) dmem[host_maddr] <= host_mdata;
        if (rst_n && mem_req && mem_we && mem_ready) dmem[mem_addr[7:0]] <= mem_wdata;
        if (!rst_n || !mem_req || mem_ready) begin
            wcnt      <= 0;
            mem_ready <= 1'b0;
        end else if (wcnt >= lat) begin
            mem_ready <= 1'b1;
        end else begin
            wcnt <= wcnt + 1;
        end
    end

    // Descriptor memory, one-cycle read latency.
    always @(posedge clk) begin
        if (host_dwr) ddesc[host_didx] <= host_dval;
        if (desc_rd_en) desc_rdata <= ddesc[desc_idx];
        if (rst_n && desc_wr_en) ddesc[desc_idx][15:0] <= desc_wr_cnt;
    end

    // Per-cycle comparison of observed events with the predicted stream.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_req && mem_we && mem_ready) begin
                longint unsigned obs;
                obs = {32'h0, mem_addr, mem_wdata};
                if (q_wr.size() == 0) check(0, "R3", "unexpected write", obs, 0);
                else begin
                    longint unsigned e;
                    e = q_wr.pop_front();
                    check(obs == e, "R3", "write addr/data", obs, e);
                end
            end
            if (desc_wr_en) begin
                longint unsigned obs;
                obs = {44'h0, desc_idx, desc_wr_cnt};
                if (q_wb.size() == 0) check(0, "R4", "unexpected write-back", obs, 0);
                else begin
                    longint unsigned e;
                    e = q_wb.pop_front();
                    check(obs == e, "R4", "write-back idx/count", obs, e);
                end
            end
            if ((flag_clr != '0) || (en_clr != '0) || cpu_irq) begin
                longint unsigned obs;
                int osrc;
                osrc = cpu_irq ? int'(irq_src) : 0;
                for (int i = 0; i < NSRC; i++) if (flag_clr[i] || en_clr[i]) osrc = i;
                obs = longint'(osrc * 8 + ((flag_clr != '0) ? 1 : 0)
                      + (cpu_irq ? 2 : 0) + ((en_clr != '0) ? 4 : 0));
                if (q_out.size() == 0) check(0, "R5", "outcome with none expected", obs, 0);
                else begin
                    longint unsigned e;
                    string tag;
                    e = q_out.pop_front();
                    tag = e[2] ? "R8" : (e[1] ? "R7" : "R6");
                    check(obs == e, tag, "outcome src/kind", obs, e);
                end
            end
        end
    end

    // Behavioural model: serve every enabled pending source in priority order.
    task automatic predict();
        for (int act = 0; act < NSRC; act++) begin
            logic [NSRC-1:0] p;
            int s;
            int idx;
            p = m_flag & m_en;
            if (p == '0) return;
            s = 0;
            for (int i = NSRC - 1; i >= 0; i--) if (p[i]) s = i;
            idx = s * 2;
            for (int step = 0; step < NDESC; step++) begin
                logic [7:0]  mode;
                logic [15:0] sa, da, c;
                mode = mdesc[idx][55:48];
                sa   = mdesc[idx][47:32];
                da   = mdesc[idx][31:16];
                c    = mdesc[idx][15:0];
                q_wr.push_back({32'h0, da, mmem[sa[7:0]]});
                mmem[da[7:0]] = mmem[sa[7:0]];
                c = c - 16'd1;
                mdesc[idx][15:0] = c;
                q_wb.push_back(longint'(idx) * 65536 + longint'(c));
                if (mode[7]) begin
                    idx = (idx + 1) % NDESC;
                end else begin
                    if (c == 16'd0) begin
                        q_out.push_back(longint'(s * 8 + 6));
                        m_en[s] = 1'b0;
                    end else if (mode[6]) begin
                        q_out.push_back(longint'(s * 8 + 2));
                    end else begin
                        q_out.push_back(longint'(s * 8 + 1));
                    end
                    m_flag[s] = 1'b0;
                    break;
                end
            end
        end
    endtask

    task automatic put_desc(int i, logic [7:0] mode, logic [15:0] sa, logic [15:0] da, logic [15:0] c);
        @(negedge clk);
        host_dwr  = 1'b1;
        host_didx = IDX_W'(i);
        host_dval = {mode, sa, da, c};
        mdesc[i]  = {mode, sa, da, c};
        @(negedge clk);
        host_dwr = 1'b0;
    endtask

    task automatic put_mem(int a, logic [15:0] v);
        @(negedge clk);
        host_mwr   = 1'b1;
        host_maddr = 8'(a);
        host_mdata = v;
        mmem[a]    = v;
        @(negedge clk);
        host_mwr = 1'b0;
    endtask

    task automatic enable(logic [NSRC-1:0] m);
        @(negedge clk);
        en_set = m;
        m_en   = m_en | m;
        @(negedge clk);
        en_set = '0;
    endtask

    task automatic raise(logic [NSRC-1:0] m);
        @(negedge clk);
        set_req = m;
        m_flag  = m_flag | m;
        @(negedge clk);
        set_req = '0;
    endtask

    task automatic wait_done(string req);
        int n;
        n = 0;
        @(negedge clk);
        while ((q_wr.size() != 0 || q_wb.size() != 0 || q_out.size() != 0 || busy) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n < 2000, req, "activation did not complete", n, 0);
        check(q_wr.size() + q_wb.size() + q_out.size() == 0, req, "events left over",
              q_wr.size() + q_wb.size() + q_out.size(), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "R10", "watchdog expired", 0, 1);
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        set_req = '0; en_set = '0; host_mwr = 0; host_dwr = 0;
        host_maddr = '0; host_mdata = '0; host_didx = '0; host_dval = '0;
        m_flag = '0; m_en = '0; lat = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet after reset
        check(!busy && !mem_req && !desc_rd_en && !desc_wr_en, "R10", "idle after reset",
              {busy, mem_req, desc_rd_en, desc_wr_en}, 0);
        check(flag_clr == '0 && en_clr == '0 && !cpu_irq, "R10", "no pulses after reset",
              {flag_clr, en_clr, cpu_irq}, 0);

        // R6, R3: source 2, select 0, count 5 -> flag cleared by block
        put_mem(8'h10, 16'hA5A5);
        put_desc(4, 8'h00, 16'h0010, 16'h0020, 16'd5);
        enable(8'h04);
        raise(8'h04);
        predict();
        wait_done("R6");
        check(src_flag[2] == 1'b0 && src_en[2] == 1'b1, "R6", "flag cleared, enable kept",
              {src_flag[2], src_en[2]}, 2'b01);

        // R4: second activation resumes from written-back count 4 -> 3
        lat = 2;
        put_mem(8'h10, 16'h1234);
        raise(8'h04);
        predict();
        wait_done("R4");
        check(dmem[8'h20] == 16'h1234, "R3", "destination holds copied word", dmem[8'h20], 16'h1234);

        // R7: source 1, select 1 -> interrupt forwarded
        lat = 3;
        put_mem(8'h11, 16'h0F0F);
        put_desc(2, 8'h40, 16'h0011, 16'h0021, 16'd9);
        enable(8'h02);
        raise(8'h02);
        predict();
        wait_done("R7");

        // R8: source 3, count 1 -> enable cleared, interrupt forwarded
        lat = 0;
        put_mem(8'h12, 16'hBEEF);
        put_desc(6, 8'h00, 16'h0012, 16'h0022, 16'd1);
        enable(8'h08);
        raise(8'h08);
        predict();
        wait_done("R8");
        check(src_en[3] == 1'b0, "R8", "source enable cleared", src_en[3], 0);
        // A flag on the disabled source starts nothing (R2, R8)
        raise(8'h08);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (busy) seen++;
            end
            check(seen == 0, "R2", "disabled source ignored", seen, 0);
        end

        // R5, R1: chain of two, first step's count hits 0, reserved bits set
        lat = 1;
        put_mem(8'h13, 16'h5555);
        put_mem(8'h14, 16'h6666);
        put_desc(0, 8'hBF, 16'h0013, 16'h0023, 16'd1);
        put_desc(1, 8'h15, 16'h0014, 16'h0024, 16'd3);
        enable(8'h01);
        raise(8'h01);
        predict();
        wait_done("R5");
        check(src_en[0] == 1'b1, "R5", "chained zero count keeps enable", src_en[0], 1);
        check(dmem[8'h24] == 16'h6666, "R1", "second chained word copied", dmem[8'h24], 16'h6666);

        // R2: sources 5,6,7 flagged, 6 not enabled -> 5 then 7
        lat = 2;
        put_mem(8'h15, 16'h7777);
        put_mem(8'h16, 16'h8888);
        put_desc(10, 8'h40, 16'h0015, 16'h0025, 16'd4);
        put_desc(14, 8'h00, 16'h0016, 16'h0026, 16'd4);
        put_desc(12, 8'h00, 16'h0017, 16'h0027, 16'd4);
        enable(8'hA0);
        raise(8'hE0);
        predict();
        wait_done("R2");
        check(src_flag[6] == 1'b1, "R2", "unenabled flag untouched", src_flag[6], 1);

        // R9: count 0 wraps to 65535, not an end
        lat = 0;
        put_mem(8'h18, 16'h9999);
        put_desc(8, 8'h00, 16'h0018, 16'h0028, 16'd0);
        enable(8'h10);
        raise(8'h10);
        predict();
        wait_done("R9");
        check(src_en[4] == 1'b1, "R9", "wrapped count keeps enable", src_en[4], 1);

        // R2: lower source raised mid-transfer is served after the current one
        lat = 5;
        raise(8'h10);
        predict();
        while (!busy) @(negedge clk);
        raise(8'h02);
        predict();
        wait_done("R2");

        check(!busy && !mem_req, "R10", "idle at end", {busy, mem_req}, 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule